// File: doc/BRIEF.md
# Queued Command Completion Reporter

This block gathers completions of natively queued disk commands, each identified by a tag, and turns them into a single completion report for the host. Every completion strobe sets one bit in a 32-bit finished-tag mask. The tag is carried in bits 7:3 of the tag byte of the queued-command frame. Many completions may pile up between reports, and all of them are merged into the next one.

When a report is requested and frame reception is both enabled and backed by a mapped receive area, the block does five things on the same clock edge. It builds an 8-byte set-device-bits record, updates its copy of the task-file data register, and presents the finished mask as a clear mask for the SATA-active vector. It also pulses either the task-file-error interrupt or the set-device-bits interrupt, then empties the finished mask. While reception is off, a report request does nothing at all, and completions stay pending until a later report. Writing the record into memory is handled outside this block.

Top module: `qcr_reporter`

## Requirements
- R1: After reset the task-file output is 0x007F. `rec_valid`, `irq_tfe` and `irq_sdb` are low, and the finished mask is empty, so the first enabled report carries a zero payload.
- R2: A `cpl_valid` strobe sets finished-mask bit `cpl_tag_byte[7:3]`. Bits 2:0 of the tag byte have no effect.
- R3: A report's record bytes are: byte 0 = 0xA1 (frame type), byte 1 = 0x40 (interrupt flag), byte 2 = `dev_status` AND 0x77, byte 3 = `dev_error`. `rec_data[8*k+7:8*k]` holds byte k.
- R4: Record bytes 4 to 7 hold the finished mask in little-endian order, so `rec_data[63:32]` equals the mask.
- R5: On a report, the new task-file value is (`dev_error` << 8) | (`dev_status` AND 0x77) | (old task-file AND 0x0088). The task-file value holds otherwise.
- R6: On a report, `act_clr` equals the reported finished mask, and the finished mask is then empty.
- R7: A report pulses `irq_tfe` for one cycle if `dev_status` bit 0 is set, and `irq_sdb` otherwise. Exactly one of the two pulses, and only together with `rec_valid`.
- R8: A report request with `fis_rx_en` low or `rx_area_mapped` low produces no record, no interrupt and no task-file change. The finished mask is kept.
- R9: A completion in the same cycle as a report is not part of that report. It appears in the next one.
- R10: Several completions between reports appear together in a single report.
- R11: Outputs are registered. A report requested in the cycle before clock edge N is visible after edge N and lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpl_valid | input | 1 | One queued command finished this cycle |
| cpl_tag_byte | input | 8 | Tag byte of the finished command; tag in bits 7:3 |
| report_req | input | 1 | Request to emit a completion report |
| dev_status | input | 8 | Current device status byte (bit 0 = error) |
| dev_error | input | 8 | Current device error byte |
| fis_rx_en | input | 1 | Frame reception enabled |
| rx_area_mapped | input | 1 | Receive area is mapped |
| rec_valid | output | 1 | One-cycle pulse: record and updates are valid |
| rec_data | output | 64 | Set-device-bits record, byte 0 in bits 7:0 |
| tfd | output | 16 | Task-file data register value |
| act_clr | output | 32 | Bits to clear in the SATA-active vector |
| irq_tfe | output | 1 | Task-file-error interrupt pulse |
| irq_sdb | output | 1 | Set-device-bits interrupt pulse |

## Verification
The assertions assume inputs change only between clock edges. They also assume `rst_n` is held for at least one edge, so the task-file register starts from its reset value before any stability check applies. The stimulus drives every input on the falling edge and keeps reset low over the first edges. Report requests are issued in enabled, disabled and unmapped settings, with completions placed before, during and after the report cycle. Status bytes in the stimulus include error-bit and old-bit-preservation cases, so both interrupt branches are reached.

// File: rtl/qcr_pkg.sv
package qcr_pkg;
  localparam logic [7:0]  SDB_KIND      = 8'hA1;
  localparam logic [7:0]  SDB_FLAGS     = 8'h40;
  localparam logic [7:0]  STATUS_PASS   = 8'h77;
  localparam logic [15:0] TFD_KEEP      = 16'h0088;
  localparam logic [15:0] TFD_AT_RESET  = 16'h007F;
  localparam int          STATUS_ERR_IX = 0;
  localparam int          TAG_LSB       = 3;

  typedef struct packed {
    logic [31:0] payload;
    logic [7:0]  error;
    logic [7:0]  status;
    logic [7:0]  flags;
    logic [7:0]  kind;
  } sdb_rec_t;
endpackage

// File: rtl/qcr_tag_accum.sv
module qcr_tag_accum #(
  parameter int TAG_W = 5,
  localparam int SLOTS = 1 << TAG_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cpl_valid,
  input  logic [TAG_W-1:0] cpl_tag,
  input  logic             flush,
  output logic [SLOTS-1:0] mask_q
);
  logic [SLOTS-1:0] hot;
  logic [SLOTS-1:0] mask_d;

  for (genvar g = 0; g < SLOTS; g++) begin : g_dec
    assign hot[g] = cpl_valid && (cpl_tag == TAG_W'(g));
  end

  // a completion landing with a flush survives into the fresh mask
  always_comb begin
    mask_d = (flush ? '0 : mask_q) | hot;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q <= '0;
    else        mask_q <= mask_d;
  end
endmodule

// File: rtl/qcr_record_build.sv
module qcr_record_build
  import qcr_pkg::*;
#(
  parameter int TAG_W = 5,
  localparam int SLOTS = 1 << TAG_W
) (
  input  logic [SLOTS-1:0] mask,
  input  logic [7:0]       dev_status,
  input  logic [7:0]       dev_error,
  input  logic [15:0]      tfd_old,
  output sdb_rec_t         rec,
  output logic [15:0]      tfd_new,
  output logic             err_seen
);
  logic [7:0] st_m;

  always_comb begin
    st_m                  = dev_status & STATUS_PASS;
    rec.kind              = SDB_KIND;
    rec.flags             = SDB_FLAGS;
    rec.status            = st_m;
    rec.error             = dev_error;
    rec.payload           = '0;
    rec.payload[SLOTS-1:0] = mask;
    tfd_new               = {dev_error, st_m} | (tfd_old & TFD_KEEP);
    err_seen              = st_m[STATUS_ERR_IX];
  end
endmodule

// File: rtl/qcr_report_reg.sv
module qcr_report_reg
  import qcr_pkg::*;
#(
  parameter int TAG_W = 5,
  localparam int SLOTS = 1 << TAG_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire,
  input  sdb_rec_t         rec_in,
  input  logic [15:0]      tfd_in,
  input  logic [SLOTS-1:0] mask_in,
  input  logic             err_in,
  output logic             rec_valid,
  output sdb_rec_t         rec_q,
  output logic [15:0]      tfd_q,
  output logic [SLOTS-1:0] clr_q,
  output logic             tfe_q,
  output logic             sdb_q
);
  logic     valid_d, tfe_d, sdb_d;

  always_comb begin
    valid_d = fire;
    tfe_d   = fire && err_in;
    sdb_d   = fire && !err_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rec_valid <= 1'b0;
      tfe_q     <= 1'b0;
      sdb_q     <= 1'b0;
    end else begin
      rec_valid <= valid_d;
      tfe_q     <= tfe_d;
      sdb_q     <= sdb_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rec_q <= '0;
      tfd_q <= TFD_AT_RESET;
      clr_q <= '0;
    end else if (fire) begin
      rec_q <= rec_in;
      tfd_q <= tfd_in;
      clr_q <= mask_in;
    end
  end
endmodule

// File: rtl/qcr_reporter.sv
module qcr_reporter
  import qcr_pkg::*;
#(
  parameter int TAG_W = 5,
  localparam int SLOTS = 1 << TAG_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cpl_valid,
  input  logic [7:0]       cpl_tag_byte,
  input  logic             report_req,
  input  logic [7:0]       dev_status,
  input  logic [7:0]       dev_error,
  input  logic             fis_rx_en,
  input  logic             rx_area_mapped,
  output logic             rec_valid,
  output logic [63:0]      rec_data,
  output logic [15:0]      tfd,
  output logic [SLOTS-1:0] act_clr,
  output logic             irq_tfe,
  output logic             irq_sdb
);
  logic [TAG_W-1:0] tag;
  logic             fire;
  logic [SLOTS-1:0] mask;
  sdb_rec_t         rec_c, rec_r;
  logic [15:0]      tfd_c;
  logic             err_c;

  assign tag  = TAG_W'(cpl_tag_byte >> TAG_LSB);
  assign fire = report_req && fis_rx_en && rx_area_mapped;

  qcr_tag_accum #(.TAG_W(TAG_W)) u_accum (
    .clk(clk), .rst_n(rst_n), .cpl_valid(cpl_valid), .cpl_tag(tag),
    .flush(fire), .mask_q(mask)
  );

  qcr_record_build #(.TAG_W(TAG_W)) u_build (
    .mask(mask), .dev_status(dev_status), .dev_error(dev_error),
    .tfd_old(tfd), .rec(rec_c), .tfd_new(tfd_c), .err_seen(err_c)
  );

  qcr_report_reg #(.TAG_W(TAG_W)) u_reg (
    .clk(clk), .rst_n(rst_n), .fire(fire), .rec_in(rec_c), .tfd_in(tfd_c),
    .mask_in(mask), .err_in(err_c), .rec_valid(rec_valid), .rec_q(rec_r),
    .tfd_q(tfd), .clr_q(act_clr), .tfe_q(irq_tfe), .sdb_q(irq_sdb)
  );

  assign rec_data = rec_r;
endmodule

// File: rtl/qcr_reporter_chk.sv
module qcr_reporter_chk #(
  parameter int TAG_W = 5,
  localparam int SLOTS = 1 << TAG_W
) (
  input logic             clk,
  input logic             rst_n,
  input logic             report_req,
  input logic             fis_rx_en,
  input logic             rx_area_mapped,
  input logic             rec_valid,
  input logic [63:0]      rec_data,
  input logic [15:0]      tfd,
  input logic [SLOTS-1:0] act_clr,
  input logic             irq_tfe,
  input logic             irq_sdb
);
  logic go;
  assign go = report_req && fis_rx_en && rx_area_mapped;

  a_r7_one_irq: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq_tfe && irq_sdb));
  a_r7_irq_tracks_record: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid == (irq_tfe || irq_sdb));
  a_r3_header_bytes: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid |-> rec_data[15:0] == 16'h40A1);
  a_r8_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !go |=> !rec_valid && $stable(tfd));
  a_r11_follows_request: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> rec_valid);
  a_r5_old_bits_kept: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> (tfd[7] == $past(tfd[7])) && (tfd[3] == $past(tfd[3])));
  a_r6_clear_is_payload: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid |-> 32'(act_clr) == rec_data[63:32]);
endmodule

bind qcr_reporter qcr_reporter_chk #(.TAG_W(TAG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .report_req(report_req), .fis_rx_en(fis_rx_en),
  .rx_area_mapped(rx_area_mapped), .rec_valid(rec_valid), .rec_data(rec_data),
  .tfd(tfd), .act_clr(act_clr), .irq_tfe(irq_tfe), .irq_sdb(irq_sdb)
);

// File: tb/test_qcr_reporter.sv
module test_qcr_reporter;
  logic        clk, rst_n;
  logic        cpl_valid, report_req, fis_rx_en, rx_area_mapped;
  logic [7:0]  cpl_tag_byte, dev_status, dev_error;
  logic        rec_valid, irq_tfe, irq_sdb;
  logic [63:0] rec_data;
  logic [15:0] tfd;
  logic [31:0] act_clr;

  int checks = 0, fails = 0, cyc = 0;
  logic [15:0] tfd_model;
  bit done = 0;

  qcr_reporter i_qcr_reporter (
    .clk(clk), .rst_n(rst_n), .cpl_valid(cpl_valid), .cpl_tag_byte(cpl_tag_byte),
    .report_req(report_req), .dev_status(dev_status), .dev_error(dev_error),
    .fis_rx_en(fis_rx_en), .rx_area_mapped(rx_area_mapped), .rec_valid(rec_valid),
    .rec_data(rec_data), .tfd(tfd), .act_clr(act_clr), .irq_tfe(irq_tfe),
    .irq_sdb(irq_sdb)
  );

  initial clk = 0;
  always #10 clk = ~clk;

  // entry: {mask[48:17], status[16:9], error[8:1], expect_tfe[0]}
  localparam logic [48:0] VECS [5] = '{
    {32'h0000_0001, 8'h50, 8'h00, 1'b0},
    {32'h8001_0000, 8'hD9, 8'h04, 1'b1},
    {32'hA5A5_0F0F, 8'hFF, 8'hAB, 1'b1},
    {32'h0000_0000, 8'h40, 8'h00, 1'b0},
    {32'h1234_5678, 8'h88, 8'h00, 1'b0}
  };

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic complete(input logic [4:0] t, input logic [2:0] noise);
    cpl_valid = 1; cpl_tag_byte = {t, noise};
    step();
    cpl_valid = 0;
  endtask

  // issues an enabled report and checks every output against the model
  task automatic report_chk(input logic [31:0] m, input logic [7:0] st,
                            input logic [7:0] er, input logic tfe, input string tag);
    report_req = 1; dev_status = st; dev_error = er;
    step();
    report_req = 0;
    tfd_model = {er, st & 8'h77} | (tfd_model & 16'h0088);
    chk({tag, " R11 valid"}, 64'(rec_valid), 64'd1);
    chk({tag, " R3 header/status/error"}, 64'(rec_data[31:0]), 64'({er, st & 8'h77, 8'h40, 8'hA1}));
    chk({tag, " R4 payload"}, 64'(rec_data[63:32]), 64'(m));
    chk({tag, " R5 tfd"}, 64'(tfd), 64'(tfd_model));
    chk({tag, " R6 act_clr"}, 64'(act_clr), 64'(m));
    chk({tag, " R7 irq"}, 64'({irq_tfe, irq_sdb}), 64'({tfe, ~tfe}));
    step();
    chk({tag, " R11 pulse ends"}, 64'({rec_valid, irq_tfe, irq_sdb}), 64'd0);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=%0d expected<100000", cyc);
      $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 0; cpl_valid = 0; cpl_tag_byte = 0; report_req = 0;
    dev_status = 0; dev_error = 0; fis_rx_en = 1; rx_area_mapped = 1;
    tfd_model = 16'h007F;
    step(); step();
    rst_n = 1;
    step();
    // R1: reset state
    chk("R1 tfd", 64'(tfd), 64'h7F);
    chk("R1 pulses", 64'({rec_valid, irq_tfe, irq_sdb}), 64'd0);

    // R2 R10: vector table, noise in tag bits 2:0
    for (int v = 0; v < 5; v++) begin
      for (int t = 0; t < 32; t++)
        if (VECS[v][17+t]) complete(5'(t), 3'(t + v));
      report_chk(VECS[v][48:17], VECS[v][16:9], VECS[v][8:1], VECS[v][0], "vec");
    end

    // R2: same tag twice with different low bits sets only its bit
    complete(5'd7, 3'b000);
    complete(5'd7, 3'b111);
    report_chk(32'h0000_0080, 8'h50, 8'h00, 1'b0, "R2 dup");

    // R8: disabled and unmapped reports keep everything
    complete(5'd5, 3'b010);
    fis_rx_en = 0; report_req = 1; dev_status = 8'h01; dev_error = 8'hEE;
    step();
    chk("R8 no record rx off", 64'({rec_valid, irq_tfe, irq_sdb}), 64'd0);
    chk("R8 tfd kept rx off", 64'(tfd), 64'(tfd_model));
    fis_rx_en = 1; rx_area_mapped = 0;
    step();
    report_req = 0; rx_area_mapped = 1;
    chk("R8 no record unmapped", 64'({rec_valid, irq_tfe, irq_sdb}), 64'd0);
    chk("R8 tfd kept unmapped", 64'(tfd), 64'(tfd_model));
    report_chk(32'h0000_0020, 8'h51, 8'h10, 1'b1, "R8 mask kept");

    // R9: completion in the report cycle goes to the next report
    complete(5'd3, 3'b001);
    cpl_valid = 1; cpl_tag_byte = {5'd9, 3'b000};
    report_chk(32'h0000_0008, 8'h40, 8'h00, 1'b0, "R9 first");
    cpl_valid = 0;
    report_chk(32'h0000_0200, 8'h40, 8'h00, 1'b0, "R9 held");

    // R1: empty mask after reset gives zero payload
    rst_n = 0; step(); rst_n = 1; step();
    tfd_model = 16'h007F;
    report_chk(32'h0, 8'h00, 8'h00, 1'b0, "R1 post-reset");

    done = 1;
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule